// File: doc/BRIEF.md
# Minimal Adaptive Route Computation Unit

This unit performs route computation and virtual-channel selection for the head flit of a packet in one router of a two-dimensional mesh. It receives the destination coordinates, the router's own position, the virtual network of the packet and an escape flag that travels with the packet. It also receives, for each of the four mesh output directions, the free state of every virtual channel together with a credit count and the clock frequency reported by the neighbouring router. From these it picks one productive output direction and one channel. It also returns the escape flag that the flit carries on to the next hop.

The channels of every virtual network are split into two classes. The low-numbered channels are escape channels and the remaining channels are adaptive. The unit first tries to grant a minimal direction that has a free adaptive channel. A two-bit policy input sets which of two such directions it prefers. If no minimal direction has a free adaptive channel, the packet falls back to dimension-ordered XY routing on an escape channel. From that hop on, the packet stays on XY and escape channels. If even that escape channel is busy, the unit reports a stall and the request must be presented again.

Top module: `noc_adaptive_route`

## Requirements
- R1: The result appears on the first rising clock edge after a request with `req_valid` high, and `rsp_valid` is high for exactly that cycle. While `rsp_valid` is low, and during reset, all result outputs are zero.
- R2: When the destination equals the router's own coordinates, the result is port 0 (local ejection), channel 0, escape 0 and stall 0, whatever the escape flag and channel state.
- R3: Every non-local result is a productive direction. The codes are east 1 when the destination x is larger than the router's x, west 2 when it is smaller, north 3 when the destination y is larger, and south 4 when it is smaller.
- R4: Channels 0 to ESC_VCS-1 (channel 0 by default) form the escape class. An adaptive grant uses the lowest-numbered free channel at or above ESC_VCS on the chosen port, with escape out 0.
- R5: Free bit ((d*NUM_VNET)+n)*VC_PER_VNET+c of `vc_free` refers to channel c of virtual network n on mesh direction d, where east=0, west=1, north=2 and south=3. Fields d*CRED_W and d*FREQ_W of `port_credits` and `port_freq` use the same direction order.
- R6: Policy 0 (and the unused code 3) takes the x-direction candidate whenever it has a free adaptive channel, and otherwise takes the y-direction candidate.
- R7: Policy 1 takes the candidate with the larger credit count. A tie goes to the x direction.
- R8: Policy 2 takes the candidate whose neighbour reports the higher frequency. A tie goes to the x direction.
- R9: When no productive direction has a free adaptive channel, the result is the XY port (x direction if x differs, else y) on the lowest free escape channel, with escape out 1.
- R10: When the escape flag is set on the request, adaptive channels are never used. The result follows R9 even if adaptive channels are free.
- R11: When the XY port has no free escape channel in the case of R9 or R10, stall is 1, the port is the XY port, the channel is 0 and escape out equals the request's escape flag.
- R12: Only the free bits of the requested virtual network affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Head-flit route request |
| req_dst_x | input | COORD_W | Destination column |
| req_dst_y | input | COORD_W | Destination row |
| req_vnet | input | VNET_W | Virtual network of the packet |
| req_escape | input | 1 | Packet already travels on escape channels |
| policy | input | 2 | Port preference: 0 first, 1 credits, 2 frequency |
| here_x | input | COORD_W | Column of this router |
| here_y | input | COORD_W | Row of this router |
| vc_free | input | 4*NUM_VNET*VC_PER_VNET | Free state of every channel per direction |
| port_credits | input | 4*CRED_W | Credit count per mesh direction |
| port_freq | input | 4*FREQ_W | Neighbour frequency code per direction |
| rsp_valid | output | 1 | Result valid |
| rsp_port | output | 3 | Chosen output port code |
| rsp_vc | output | VC_W | Chosen channel within the virtual network |
| rsp_escape | output | 1 | Escape flag to carry forward |
| rsp_stall | output | 1 | No channel granted; retry |

## Verification
A wrong selection state shows at the ports one cycle after the faulty request. A wrong class boundary puts an adaptive grant on channel 0 or an escape grant above it. A wrong direction decode yields a non-productive port code. A wrong virtual-network slice changes the stall or channel for requests whose own network state does not justify it. Random requests with sparse free vectors cover all three policies and the fallback and stall paths. Directed cases pin down the ties and the local destination.

// File: rtl/noc_route_pkg.sv
package noc_route_pkg;

   localparam int MESH_DIRS = 4;

   typedef enum logic [2:0] {
      PORT_LOCAL = 3'd0,
      PORT_EAST  = 3'd1,
      PORT_WEST  = 3'd2,
      PORT_NORTH = 3'd3,
      PORT_SOUTH = 3'd4
   } port_e;

   typedef enum logic [1:0] {
      POL_FIRST = 2'd0,
      POL_LOAD  = 2'd1,
      POL_FREQ  = 2'd2,
      POL_SPARE = 2'd3
   } policy_e;

   // mesh direction index (east=0 .. south=3) of a non-local port code
   function automatic logic [1:0] dir_index(port_e p);
      return 2'(int'(p) - 1);
   endfunction

endpackage

// File: rtl/noc_route_dir.sv
module noc_route_dir
   import noc_route_pkg::*;
#(
   parameter int COORD_W = 2
) (
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   output logic               at_home,
   output logic               x_live,
   output logic               y_live,
   output port_e              x_port,
   output port_e              y_port,
   output port_e              xy_port
);
   always_comb begin
      x_live  = (dst_x != cur_x);
      y_live  = (dst_y != cur_y);
      at_home = !x_live && !y_live;
      x_port  = (dst_x > cur_x) ? PORT_EAST  : PORT_WEST;
      y_port  = (dst_y > cur_y) ? PORT_NORTH : PORT_SOUTH;
      xy_port = x_live ? x_port : y_port;
   end
endmodule

// File: rtl/noc_vc_pick.sv
module noc_vc_pick #(
   parameter int VC_PER_VNET = 4,
   parameter int ESC_VCS     = 1,
   localparam int VC_W       = (VC_PER_VNET > 1) ? $clog2(VC_PER_VNET) : 1
) (
   input  logic [VC_PER_VNET-1:0] free,
   output logic                   adapt_any,
   output logic [VC_W-1:0]        adapt_idx,
   output logic                   esc_any,
   output logic [VC_W-1:0]        esc_idx
);
   // descending scans leave the lowest free index in each class
   always_comb begin
      adapt_any = 1'b0;
      adapt_idx = '0;
      for (int v = VC_PER_VNET - 1; v >= ESC_VCS; v--) begin
         if (free[v]) begin
            adapt_any = 1'b1;
            adapt_idx = VC_W'(v);
         end
      end
   end

   always_comb begin
      esc_any = 1'b0;
      esc_idx = '0;
      for (int v = ESC_VCS - 1; v >= 0; v--) begin
         if (free[v]) begin
            esc_any = 1'b1;
            esc_idx = VC_W'(v);
         end
      end
   end
endmodule

// File: rtl/noc_port_rank.sv
module noc_port_rank
   import noc_route_pkg::*;
#(
   parameter int CRED_W = 4,
   parameter int FREQ_W = 4
) (
   input  policy_e           policy,
   input  logic              x_ok,
   input  logic              y_ok,
   input  logic [CRED_W-1:0] x_cred,
   input  logic [CRED_W-1:0] y_cred,
   input  logic [FREQ_W-1:0] x_freq,
   input  logic [FREQ_W-1:0] y_freq,
   output logic              any_ok,
   output logic              take_y
);
   logic y_better;

   always_comb begin
      unique case (policy)
         POL_LOAD: y_better = (y_cred > x_cred);
         POL_FREQ: y_better = (y_freq > x_freq);
         default:  y_better = 1'b0;
      endcase
      any_ok = x_ok || y_ok;
      take_y = y_ok && (!x_ok || y_better);
   end
endmodule

// File: rtl/noc_adaptive_route.sv
module noc_adaptive_route
   import noc_route_pkg::*;
#(
   parameter int MESH_X      = 4,
   parameter int MESH_Y      = 4,
   parameter int NUM_VNET    = 3,
   parameter int VC_PER_VNET = 4,
   parameter int ESC_VCS     = 1,
   parameter int CRED_W      = 4,
   parameter int FREQ_W      = 4,
   localparam int MESH_MAX   = (MESH_X > MESH_Y) ? MESH_X : MESH_Y,
   localparam int COORD_W    = (MESH_MAX > 1) ? $clog2(MESH_MAX) : 1,
   localparam int VNET_W     = (NUM_VNET > 1) ? $clog2(NUM_VNET) : 1,
   localparam int VC_W       = (VC_PER_VNET > 1) ? $clog2(VC_PER_VNET) : 1,
   localparam int FREE_W     = MESH_DIRS * NUM_VNET * VC_PER_VNET
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [COORD_W-1:0]          req_dst_x,
   input  logic [COORD_W-1:0]          req_dst_y,
   input  logic [VNET_W-1:0]           req_vnet,
   input  logic                        req_escape,
   input  logic [1:0]                  policy,
   input  logic [COORD_W-1:0]          here_x,
   input  logic [COORD_W-1:0]          here_y,
   input  logic [FREE_W-1:0]           vc_free,
   input  logic [MESH_DIRS*CRED_W-1:0] port_credits,
   input  logic [MESH_DIRS*FREQ_W-1:0] port_freq,
   output logic                        rsp_valid,
   output logic [2:0]                  rsp_port,
   output logic [VC_W-1:0]             rsp_vc,
   output logic                        rsp_escape,
   output logic                        rsp_stall
);
   // elaboration-time parameter checks
   if (VC_PER_VNET < 2) begin : g_bad_vcs
      $error("VC_PER_VNET must be at least 2");
   end
   if (ESC_VCS < 1 || ESC_VCS >= VC_PER_VNET) begin : g_bad_esc
      $error("ESC_VCS must leave at least one channel in each class");
   end
   if (MESH_X < 2 || MESH_Y < 2 || NUM_VNET < 1) begin : g_bad_mesh
      $error("mesh must be at least 2x2 with one virtual network");
   end

   logic  at_home, x_live, y_live;
   port_e x_port, y_port, xy_port;

   noc_route_dir #(.COORD_W(COORD_W)) i_dir (
      .cur_x(here_x), .cur_y(here_y), .dst_x(req_dst_x), .dst_y(req_dst_y),
      .at_home(at_home), .x_live(x_live), .y_live(y_live),
      .x_port(x_port), .y_port(y_port), .xy_port(xy_port)
   );

   // per direction: free channels of the requested virtual network only
   logic [VC_PER_VNET-1:0] dir_free [MESH_DIRS];
   logic                   dir_adapt_any [MESH_DIRS];
   logic [VC_W-1:0]        dir_adapt_idx [MESH_DIRS];
   logic                   dir_esc_any   [MESH_DIRS];
   logic [VC_W-1:0]        dir_esc_idx   [MESH_DIRS];

   for (genvar d = 0; d < MESH_DIRS; d++) begin : g_dir
      always_comb begin
         dir_free[d] = '0;
         for (int n = 0; n < NUM_VNET; n++) begin
            if (req_vnet == VNET_W'(n))
               dir_free[d] = vc_free[(d*NUM_VNET + n)*VC_PER_VNET +: VC_PER_VNET];
         end
      end

      noc_vc_pick #(.VC_PER_VNET(VC_PER_VNET), .ESC_VCS(ESC_VCS)) i_pick (
         .free(dir_free[d]),
         .adapt_any(dir_adapt_any[d]), .adapt_idx(dir_adapt_idx[d]),
         .esc_any(dir_esc_any[d]),     .esc_idx(dir_esc_idx[d])
      );
   end

   logic [1:0] xi, yi, xyi, seli;
   logic       x_ok, y_ok, any_ok, take_y;

   always_comb begin
      xi   = dir_index(x_port);
      yi   = dir_index(y_port);
      xyi  = dir_index(xy_port);
      x_ok = x_live && !req_escape && dir_adapt_any[xi];
      y_ok = y_live && !req_escape && dir_adapt_any[yi];
   end

   noc_port_rank #(.CRED_W(CRED_W), .FREQ_W(FREQ_W)) i_rank (
      .policy(policy_e'(policy)), .x_ok(x_ok), .y_ok(y_ok),
      .x_cred(port_credits[xi*CRED_W +: CRED_W]),
      .y_cred(port_credits[yi*CRED_W +: CRED_W]),
      .x_freq(port_freq[xi*FREQ_W +: FREQ_W]),
      .y_freq(port_freq[yi*FREQ_W +: FREQ_W]),
      .any_ok(any_ok), .take_y(take_y)
   );

   port_e           nxt_port;
   logic [VC_W-1:0] nxt_vc;
   logic            nxt_esc, nxt_stall;

   always_comb begin
      seli      = take_y ? yi : xi;
      nxt_port  = PORT_LOCAL;
      nxt_vc    = '0;
      nxt_esc   = 1'b0;
      nxt_stall = 1'b0;
      if (at_home) begin
         nxt_port = PORT_LOCAL;
      end else if (any_ok) begin
         nxt_port = take_y ? y_port : x_port;
         nxt_vc   = dir_adapt_idx[seli];
      end else if (dir_esc_any[xyi]) begin
         nxt_port = xy_port;
         nxt_vc   = dir_esc_idx[xyi];
         nxt_esc  = 1'b1;
      end else begin
         nxt_port  = xy_port;
         nxt_esc   = req_escape;
         nxt_stall = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_port   <= '0;
         rsp_vc     <= '0;
         rsp_escape <= 1'b0;
         rsp_stall  <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_port   <= req_valid ? 3'(nxt_port) : 3'd0;
         rsp_vc     <= req_valid ? nxt_vc : '0;
         rsp_escape <= req_valid && nxt_esc;
         rsp_stall  <= req_valid && nxt_stall;
      end
   end

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R1
   rsp_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_port == 3'd0 && !rsp_escape && !rsp_stall));

   // R2
   local_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dst_x == here_x && req_dst_y == here_y)
      |=> (rsp_port == 3'd0 && !rsp_escape && !rsp_stall));

   // R4
   adaptive_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_port != 3'd0 && !rsp_escape && !rsp_stall)
      |-> (int'(rsp_vc) >= ESC_VCS));

   // R10
   escape_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_escape && (req_dst_x != here_x || req_dst_y != here_y))
      |=> (rsp_escape && int'(rsp_vc) < ESC_VCS));

   // R3
   port_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_port <= 3'd4));
endmodule

// File: tb/test_noc_adaptive_route.sv
module test_noc_adaptive_route;
   localparam int NV = 3;
   localparam int VCS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_dst_x = '0, req_dst_y = '0, req_vnet = '0, policy = '0;
   logic        req_escape = 1'b0;
   logic [1:0]  here_x = '0, here_y = '0;
   logic [47:0] vc_free = '0;
   logic [15:0] port_credits = '0, port_freq = '0;
   logic        rsp_valid, rsp_escape, rsp_stall;
   logic [2:0]  rsp_port;
   logic [1:0]  rsp_vc;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   noc_adaptive_route i_noc_adaptive_route (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_dst_x(req_dst_x), .req_dst_y(req_dst_y), .req_vnet(req_vnet),
      .req_escape(req_escape), .policy(policy), .here_x(here_x), .here_y(here_y),
      .vc_free(vc_free), .port_credits(port_credits), .port_freq(port_freq),
      .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_vc(rsp_vc),
      .rsp_escape(rsp_escape), .rsp_stall(rsp_stall)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // expected result {stall, esc, vc[1:0], port[2:0]} from the requirements
   function automatic logic [6:0] model();
      int  adapt [4];
      bit  escf [4];
      int  xi, yi, p;
      bit  xl, yl, xo, yo, sel;
      if (req_dst_x == here_x && req_dst_y == here_y) return 7'd0;   // R2
      for (int d = 0; d < 4; d++) begin
         logic [3:0] f;
         f = vc_free[(d*NV + int'(req_vnet))*VCS +: VCS];              // R5, R12
         adapt[d] = -1;
         for (int v = 3; v >= 1; v--) if (f[v]) adapt[d] = v;        // R4
         escf[d] = f[0];
      end
      xl = req_dst_x != here_x;
      yl = req_dst_y != here_y;
      xi = (req_dst_x > here_x) ? 0 : 1;                              // R3
      yi = (req_dst_y > here_y) ? 2 : 3;
      xo = xl && !req_escape && adapt[xi] >= 0;
      yo = yl && !req_escape && adapt[yi] >= 0;
      if (xo || yo) begin
         sel = yo && (!xo ||
               (policy == 2'd1 && port_credits[yi*4 +: 4] > port_credits[xi*4 +: 4]) ||
               (policy == 2'd2 && port_freq[yi*4 +: 4] > port_freq[xi*4 +: 4]));
         p = sel ? yi : xi;
         return {1'b0, 1'b0, 2'(adapt[p]), 3'(p + 1)};
      end
      p = xl ? xi : yi;
      if (escf[p]) return {1'b0, 1'b1, 2'd0, 3'(p + 1)};             // R9
      return {1'b1, req_escape, 2'd0, 3'(p + 1)};                     // R11
   endfunction

   task automatic run(string tag);
      logic [6:0] e;
      req_valid = 1'b1;
      e = model();
      @(negedge clk);
      chk(tag, "valid", int'(rsp_valid), 1);
      chk(tag, "port", int'(rsp_port), int'(e[2:0]));
      chk(tag, "vc", int'(rsp_vc), int'(e[4:3]));
      chk(tag, "escape", int'(rsp_escape), int'(e[5]));
      chk(tag, "stall", int'(rsp_stall), int'(e[6]));
   endtask

   task automatic setup(int hx, int hy, int dx, int dy, int vn, bit esc, int pol);
      here_x = 2'(hx); here_y = 2'(hy); req_dst_x = 2'(dx); req_dst_y = 2'(dy);
      req_vnet = 2'(vn); req_escape = esc; policy = 2'(pol);
   endtask

   function automatic logic [47:0] free_one(int d, int vn, int v);
      logic [47:0] r;
      r = '0;
      r[(d*NV + vn)*VCS + v] = 1'b1;
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "reset valid", int'(rsp_valid), 0);
      chk("R1", "reset port", int'(rsp_port), 0);
      chk("R1", "reset stall", int'(rsp_stall), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 local destination ignores escape flag
      setup(2, 1, 2, 1, 0, 1'b1, 0); vc_free = '0; run("R2");

      // R6 first-available prefers x; R4 lowest adaptive channel
      setup(1, 1, 3, 3, 1, 1'b0, 0);
      vc_free = free_one(0, 1, 3) | free_one(0, 1, 2) | free_one(2, 1, 1);
      run("R6"); chk("R4", "lowest adaptive vc", int'(rsp_vc), 2);
      // R6 x blocked -> y
      vc_free = free_one(0, 1, 0) | free_one(2, 1, 3); run("R6");
      chk("R3", "north code", int'(rsp_port), 3);

      // R7 credits decide; tie goes to x
      setup(2, 2, 0, 0, 2, 1'b0, 1);
      vc_free = free_one(1, 2, 1) | free_one(3, 2, 1);
      port_credits = 16'h9_0_3_0; run("R7");
      chk("R7", "south by credit", int'(rsp_port), 4);
      port_credits = 16'h5_0_5_0; run("R7");
      chk("R7", "tie west", int'(rsp_port), 2);

      // R8 frequency decides; tie to x
      setup(0, 3, 3, 0, 0, 1'b0, 2);
      vc_free = free_one(0, 0, 3) | free_one(3, 0, 3);
      port_credits = '0; port_freq = 16'hF_0_0_2; run("R8");
      chk("R8", "south by freq", int'(rsp_port), 4);
      port_freq = 16'h2_0_0_2; run("R8");

      // R9 no adaptive -> XY escape
      setup(0, 0, 2, 2, 0, 1'b0, 0);
      vc_free = free_one(0, 0, 0) | free_one(2, 0, 0); run("R9");
      chk("R9", "escape out", int'(rsp_escape), 1);
      // R10 escape flag ignores free adaptive channels
      setup(3, 0, 3, 2, 1, 1'b1, 1);
      vc_free = free_one(2, 1, 0) | free_one(2, 1, 3); run("R10");
      chk("R10", "escape vc", int'(rsp_vc), 0);
      // R11 stall keeps request escape flag
      vc_free = free_one(2, 1, 3); run("R11");
      chk("R11", "stall", int'(rsp_stall), 1);
      // R12 other networks full, own network empty -> stall
      setup(1, 2, 3, 2, 2, 1'b0, 0);
      vc_free = ~48'd0;
      vc_free[(0*NV + 2)*VCS +: VCS] = '0;
      run("R12"); chk("R12", "stall", int'(rsp_stall), 1);

      // R1 idle cycle clears the result
      req_valid = 1'b0;
      @(negedge clk);
      chk("R1", "idle valid", int'(rsp_valid), 0);
      chk("R1", "idle port", int'(rsp_port), 0);

      for (int i = 0; i < 400; i++) begin
         logic [6:0] e;
         string tag;
         setup(int'($urandom_range(3)), int'($urandom_range(3)),
               int'($urandom_range(3)), int'($urandom_range(3)),
               int'($urandom_range(2)), 1'($urandom_range(3) == 0),
               int'($urandom_range(3)));
         vc_free = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         port_credits = 16'($urandom);
         port_freq = 16'($urandom);
         e = model();
         if (req_dst_x == here_x && req_dst_y == here_y) tag = "R2";
         else if (e[6]) tag = "R11";
         else if (req_escape) tag = "R10";
         else if (e[5]) tag = "R9";
         else if (policy == 2'd1) tag = "R7";
         else if (policy == 2'd2) tag = "R8";
         else tag = "R6";
         run(tag);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule